// File: doc/BRIEF.md
# Register Rename Unit with Free List

This block renames the 32 architectural integer registers of an out-of-order core onto a pool of 64 physical registers. It keeps two copies of the map. The speculative map is updated as instructions are renamed. The committed map is updated only as instructions retire. Physical tags that no map refers to are kept in a first-in first-out free list.

For every instruction offered on the rename port, the unit looks up the physical tags of both sources. If the instruction writes a destination, it takes a fresh tag from the head of the free list and reports the tag that the destination displaced. That displaced tag travels with the instruction. When the instruction commits, the retirement logic hands back both tags: the new tag goes into the committed map, and the displaced tag returns to the tail of the free list.

On a flush (a trap or a mispredicted branch), the speculative map is overwritten in a single cycle with the committed map. The free list read pointer is wound back, so every tag that is not in the committed map becomes free again.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i, and the free list holds tags 32 to 63, handed out in ascending order starting with 32.
- R2: `alloc_prs1` and `alloc_prs2` show, in the same cycle, the speculative mapping of `alloc_rs1` and `alloc_rs2` as it stood before any update in that cycle. Register x0 always reads tag 0.
- R3: An allocation is accepted when all of the following hold: `alloc_valid` is 1, `alloc_wr` is 1, `alloc_rd` is not 0, the free list is not empty, and `flush` is 0. For an accepted allocation, `alloc_prd` equals the free-list head, `alloc_lprd` equals the current mapping of `alloc_rd`, and `alloc_ard` equals `alloc_rd`. From the next cycle, `alloc_rd` maps to `alloc_prd` and the head is removed. A tag handed out is never 0.
- R4: An instruction with `alloc_wr` equal to 0, or with `alloc_rd` equal to 0, takes no tag. For it, `alloc_prd` and `alloc_lprd` read 0, the map is not changed, and it never stalls.
- R5: `alloc_stall` is 1 exactly when `alloc_valid` is 1, the instruction needs a tag, and the free list is empty. A stalled instruction changes nothing, even if a commit returns a tag in the same cycle.
- R6: A commit takes effect when `commit_valid` is 1, `commit_wr` is 1 and `commit_rd` is not 0. It pushes `commit_lprd` onto the tail of the free list and sets the committed map entry for `commit_rd` to `commit_prd`.
- R7: When `flush` is 1, the rename offered in that cycle is dropped. From the next cycle, the speculative map equals the committed map, including any commit made in the flush cycle. The free list then holds the tags of the dropped uncommitted allocations, oldest first, followed by the tags that were already free, in their existing order.
- R8: The free list never holds more than 32 tags, and it holds exactly 32 right after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Restore the speculative map from the committed map |
| alloc_valid | input | 1 | Rename request present |
| alloc_wr | input | 1 | Request writes a destination register |
| alloc_rs1 | input | 5 | Architectural source 1 |
| alloc_rs2 | input | 5 | Architectural source 2 |
| alloc_rd | input | 5 | Architectural destination |
| alloc_prs1 | output | 6 | Physical tag of source 1 |
| alloc_prs2 | output | 6 | Physical tag of source 2 |
| alloc_prd | output | 6 | Newly allocated destination tag, 0 if none |
| alloc_lprd | output | 6 | Displaced destination tag, 0 if none |
| alloc_ard | output | 5 | Architectural destination passed along |
| alloc_stall | output | 1 | Request needs a tag and none is free |
| commit_valid | input | 1 | Retiring instruction present |
| commit_wr | input | 1 | Retiring instruction wrote a destination |
| commit_rd | input | 5 | Architectural destination of the retiring instruction |
| commit_prd | input | 6 | Tag it was allocated |
| commit_lprd | input | 6 | Tag it displaced, returned to the free list |

## Verification
The rename port is first driven with directed patterns:
- Reading all registers after reset separates the reset map from any later state.
- Draining the free list with 32 back-to-back writes shows the ascending reset order of tags.
- One more request then shows the stall, with and without a commit in the same cycle.
- Requests that do not write, and requests that write x0, sent while the list is empty, tell "needs no tag" apart from "stalls".

A long random run then mixes the following against a queue-based model:
- renames of every destination, x0 included;
- in-order commits;
- occasional flushes, some in the same cycle as a commit.

This run tells apart the free-list ordering after recovery, the old-mapping reports when the same register is renamed repeatedly, and the same-cycle commit-and-flush case.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int NUM_ARCH = 32;
    localparam int NUM_PHYS = 64;
    localparam int AW       = $clog2(NUM_ARCH);
    localparam int PW       = $clog2(NUM_PHYS);
    localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH;
    localparam int FLW      = $clog2(FL_DEPTH);

    typedef logic [AW-1:0]        areg_t;
    typedef logic [PW-1:0]        ptag_t;
    typedef logic [FLW:0]         flptr_t;
    typedef ptag_t [NUM_ARCH-1:0] map_vec_t;

    // True when an operation really targets a renamable register.
    function automatic logic writes_dest(input logic wr, input areg_t rd);
        return wr && (rd != '0);
    endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter bit RESTORE = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  areg_t    waddr,
    input  ptag_t    wdata,
    input  logic     restore,
    input  map_vec_t restore_map,
    output map_vec_t map_q
);

    map_vec_t map_d;

    // A restore has priority over a write in the same cycle.
    always_comb begin
        map_d = map_q;
        if (RESTORE && restore) begin
            map_d = restore_map;
        end else if (we) begin
            map_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= ptag_t'(i);
            end
        end else begin
            map_q <= map_d;
        end
    end

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pop,
    input  logic   push,
    input  ptag_t  push_tag,
    input  logic   rewind,
    output ptag_t  head,
    output logic   empty,
    output flptr_t count
);

    ptag_t  slots [FL_DEPTH];
    flptr_t rd_q, wr_q, rd_d, wr_d;

    // Committed allocations leave the ring in the order they entered it.
    // So after a rewind, the FL_DEPTH slots ending at the write pointer are
    // exactly the tags missing from the committed map.
    always_comb begin
        wr_d = wr_q + flptr_t'(push);
        if (rewind) begin
            rd_d = wr_d - flptr_t'(FL_DEPTH);
        end else begin
            rd_d = rd_q + flptr_t'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FL_DEPTH; i++) begin
                slots[i] <= ptag_t'(NUM_ARCH + i);
            end
            rd_q <= '0;
            wr_q <= flptr_t'(FL_DEPTH);
        end else begin
            if (push) begin
                slots[wr_q[FLW-1:0]] <= push_tag;
            end
            rd_q <= rd_d;
            wr_q <= wr_d;
        end
    end

    assign head  = slots[rd_q[FLW-1:0]];
    assign count = wr_q - rd_q;
    assign empty = (rd_q == wr_q);

endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        alloc_valid,
    input  logic        alloc_wr,
    input  logic [4:0]  alloc_rs1,
    input  logic [4:0]  alloc_rs2,
    input  logic [4:0]  alloc_rd,
    output logic [5:0]  alloc_prs1,
    output logic [5:0]  alloc_prs2,
    output logic [5:0]  alloc_prd,
    output logic [5:0]  alloc_lprd,
    output logic [4:0]  alloc_ard,
    output logic        alloc_stall,
    input  logic        commit_valid,
    input  logic        commit_wr,
    input  logic [4:0]  commit_rd,
    input  logic [5:0]  commit_prd,
    input  logic [5:0]  commit_lprd
);

    map_vec_t spec_q, bak_q, restore_map;
    ptag_t    fl_head;
    logic     fl_empty;
    flptr_t   fl_count;
    logic     needs_tag, alloc_take, commit_take;

    assign needs_tag   = alloc_valid && writes_dest(alloc_wr, alloc_rd);
    assign alloc_stall = needs_tag && fl_empty;
    assign alloc_take  = needs_tag && !fl_empty && !flush;
    assign commit_take = commit_valid && writes_dest(commit_wr, commit_rd);

    // The restore source is the committed map with this cycle's commit applied.
    always_comb begin
        restore_map = bak_q;
        if (commit_take) begin
            restore_map[commit_rd] = commit_prd;
        end
    end

    rn_map_table #(.RESTORE(1'b1)) u_spec_map (
        .clk         (clk),
        .rst         (rst),
        .we          (alloc_take),
        .waddr       (alloc_rd),
        .wdata       (fl_head),
        .restore     (flush),
        .restore_map (restore_map),
        .map_q       (spec_q)
    );

    rn_map_table #(.RESTORE(1'b0)) u_bak_map (
        .clk         (clk),
        .rst         (rst),
        .we          (commit_take),
        .waddr       (commit_rd),
        .wdata       (commit_prd),
        .restore     (1'b0),
        .restore_map (bak_q),
        .map_q       (bak_q)
    );

    rn_free_list u_free_list (
        .clk      (clk),
        .rst      (rst),
        .pop      (alloc_take),
        .push     (commit_take),
        .push_tag (commit_lprd),
        .rewind   (flush),
        .head     (fl_head),
        .empty    (fl_empty),
        .count    (fl_count)
    );

    assign alloc_prs1 = spec_q[alloc_rs1];
    assign alloc_prs2 = spec_q[alloc_rs2];
    assign alloc_prd  = needs_tag ? fl_head : '0;
    assign alloc_lprd = needs_tag ? spec_q[alloc_rd] : '0;
    assign alloc_ard  = alloc_rd;

endmodule

// File: rtl/rn_checker.sv
module rn_checker
    import rn_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     flush,
    input logic     alloc_take,
    input logic     alloc_stall,
    input areg_t    alloc_rd,
    input ptag_t    alloc_prd,
    input logic     commit_take,
    input areg_t    commit_rd,
    input ptag_t    commit_prd,
    input flptr_t   fl_count,
    input map_vec_t spec_q,
    input map_vec_t bak_q
);

    AST_FL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(fl_count) <= FL_DEPTH); // R8

    AST_FLUSH_REFILL: assert property (@(posedge clk) disable iff (rst)
        flush |=> int'(fl_count) == FL_DEPTH); // R8

    AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (rst)
        flush |=> spec_q == bak_q); // R7

    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (rst)
        alloc_take |=> spec_q[$past(alloc_rd)] == $past(alloc_prd)); // R3

    AST_PRD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        alloc_take |-> alloc_prd != '0); // R3

    AST_BACKUP_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit_take |=> bak_q[$past(commit_rd)] == $past(commit_prd)); // R6

    AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        alloc_stall |-> fl_count == '0); // R5

    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (alloc_stall && !commit_take && !flush) |=> fl_count == '0); // R5

    AST_X0_FIXED: assert property (@(posedge clk) disable iff (rst)
        spec_q[0] == '0 && bak_q[0] == '0); // R2

endmodule

bind rename_unit rn_checker u_rn_checker (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .alloc_take  (alloc_take),
    .alloc_stall (alloc_stall),
    .alloc_rd    (alloc_rd),
    .alloc_prd   (alloc_prd),
    .commit_take (commit_take),
    .commit_rd   (commit_rd),
    .commit_prd  (commit_prd),
    .fl_count    (fl_count),
    .spec_q      (spec_q),
    .bak_q       (bak_q)
);

// File: tb/test_rename_unit.sv
module test_rename_unit;

    typedef struct packed {
        logic       wr;
        logic [4:0] rd;
        logic [5:0] prd;
        logic [5:0] lprd;
    } rob_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       alloc_valid = 1'b0, alloc_wr = 1'b0;
    logic [4:0] alloc_rs1 = '0, alloc_rs2 = '0, alloc_rd = '0;
    logic [5:0] alloc_prs1, alloc_prs2, alloc_prd, alloc_lprd;
    logic [4:0] alloc_ard;
    logic       alloc_stall;
    logic       commit_valid = 1'b0, commit_wr = 1'b0;
    logic [4:0] commit_rd = '0;
    logic [5:0] commit_prd = '0, commit_lprd = '0;

    int nchk = 0;
    int nerr = 0;

    logic [5:0] m_spec [32];
    logic [5:0] m_bak  [32];
    logic [5:0] m_free [$];
    rob_t       rob    [$];

    always #10 clk = ~clk;

    rename_unit i_rename_unit (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_wr(alloc_wr),
        .alloc_rs1(alloc_rs1), .alloc_rs2(alloc_rs2), .alloc_rd(alloc_rd),
        .alloc_prs1(alloc_prs1), .alloc_prs2(alloc_prs2),
        .alloc_prd(alloc_prd), .alloc_lprd(alloc_lprd),
        .alloc_ard(alloc_ard), .alloc_stall(alloc_stall),
        .commit_valid(commit_valid), .commit_wr(commit_wr),
        .commit_rd(commit_rd), .commit_prd(commit_prd), .commit_lprd(commit_lprd)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic needs(input logic av, input logic aw, input logic [4:0] rd);
        return av && aw && (rd != 5'd0);
    endfunction

    // One clock of stimulus: drive at the falling edge, check the outputs
    // just after it, update the model at the next rising edge.
    task automatic cycle(input logic av, input logic aw, input logic [4:0] rs1,
                         input logic [4:0] rs2, input logic [4:0] rd,
                         input logic cv, input logic fl);
        rob_t       ce;
        logic       do_commit, exp_stall, take;
        logic [5:0] p, lp;
        logic [5:0] nq [$];
        @(negedge clk);
        do_commit = cv && (rob.size() > 0);
        ce = do_commit ? rob.pop_front() : '0;
        alloc_valid  = av;  alloc_wr = aw;
        alloc_rs1    = rs1; alloc_rs2 = rs2; alloc_rd = rd;
        commit_valid = do_commit; commit_wr = ce.wr; commit_rd = ce.rd;
        commit_prd   = ce.prd;    commit_lprd = ce.lprd;
        flush        = fl;
        #1;
        chk("R2 prs1", alloc_prs1, m_spec[rs1]);
        chk("R2 prs2", alloc_prs2, m_spec[rs2]);
        exp_stall = needs(av, aw, rd) && (m_free.size() == 0);
        chk("R5 stall", alloc_stall, exp_stall);
        take = needs(av, aw, rd) && !exp_stall && !fl;
        if (needs(av, aw, rd) && !exp_stall) begin
            chk("R3 prd", alloc_prd, m_free[0]);
            chk("R3 lprd", alloc_lprd, m_spec[rd]);
            chk("R3 ard", alloc_ard, rd);
        end else if (av && !needs(av, aw, rd)) begin
            chk("R4 prd", alloc_prd, 0);
            chk("R4 lprd", alloc_lprd, 0);
        end
        @(posedge clk);
        if (take) begin
            p  = m_free.pop_front();
            lp = m_spec[rd];
            m_spec[rd] = p;
            rob.push_back({1'b1, rd, p, lp});
        end else if (av && !needs(av, aw, rd) && !fl) begin
            rob.push_back({1'b0, rd, 6'd0, 6'd0});
        end
        if (do_commit && ce.wr && ce.rd != 5'd0) begin
            m_free.push_back(ce.lprd);
            m_bak[ce.rd] = ce.prd;
        end
        if (fl) begin
            for (int i = 0; i < 32; i++) m_spec[i] = m_bak[i];
            foreach (rob[i]) if (rob[i].wr && rob[i].rd != 5'd0) nq.push_back(rob[i].prd);
            foreach (m_free[i]) nq.push_back(m_free[i]);
            m_free = nq;
            rob.delete();
        end
    endtask

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin
            m_spec[i] = 6'(i);
            m_bak[i]  = 6'(i);
            m_free.push_back(6'(32 + i));
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset map and first free tag
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            alloc_rs1 = 5'(i); alloc_rs2 = 5'(31 - i);
            #1;
            chk("R1 map rs1", alloc_prs1, i);
            chk("R1 map rs2", alloc_prs2, 31 - i);
        end
        alloc_valid = 1'b1; alloc_wr = 1'b1; alloc_rd = 5'd5;
        #1;
        chk("R1 first tag", alloc_prd, 32);
        chk("R1 no stall", alloc_stall, 0);
        alloc_valid = 1'b0;

        // R1/R3: drain the list, same rd renamed repeatedly at times
        for (int i = 0; i < 32; i++) begin
            cycle(1'b1, 1'b1, 5'd3, 5'(i), 5'(1 + (i % 7)), 1'b0, 1'b0);
        end
        // R5: empty list stalls, even with a commit in the same cycle
        cycle(1'b1, 1'b1, 5'd1, 5'd2, 5'd9, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 5'd1, 5'd2, 5'd9, 1'b1, 1'b0);
        // R4: non-writing and x0 requests never stall
        cycle(1'b1, 1'b0, 5'd4, 5'd5, 5'd9, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 5'd4, 5'd5, 5'd0, 1'b0, 1'b0);
        // R6: commit a few, then R7: flush together with a commit
        repeat (4) cycle(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 5'd1, 5'd2, 5'd6, 1'b1, 1'b1);
        for (int i = 0; i < 32; i++) begin
            cycle(1'b0, 1'b0, 5'(i), 5'(31 - i), 5'd0, 1'b0, 1'b0);
        end
        cycle(1'b1, 1'b1, 5'd6, 5'd7, 5'd6, 1'b0, 1'b0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom % 4) != 0, ($urandom % 5) != 0,
                  5'($urandom % 32), 5'($urandom % 32), 5'($urandom % 32),
                  ($urandom % 2) == 0, ($urandom % 60) == 0);
        end

        // Final flush with everything retired: map identical to backup
        while (rob.size() > 0) cycle(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0);
        cycle(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1);
        for (int i = 0; i < 32; i++) begin
            cycle(1'b0, 1'b0, 5'(i), 5'(i), 5'd0, 1'b0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule